// File: doc/BRIEF.md
# Vector Length and Type Configuration Unit

This block holds the architectural vector length (VL) and the vector type of a vector processor, and applies the state change that a set-length instruction requests. A request carries an application length, an element-width code and a register-grouping code. The unit derives the largest length the hardware can hold under the new type. It grants the smaller of that maximum and the request, and returns the granted length so that software can advance its loop pointers. On the final pass of a stripmined loop, the granted length is exactly the number of elements left. A request can instead ask to keep the current length and change only the type. Illegal settings are flagged, and the stored state stays as it was.

The unit also checks up to `NSPEC` vector register specifiers in parallel against the grouping factor currently in force. A specifier that is not a multiple of the group size is reported as an illegal-instruction condition. Decode and all vector execution sit outside this block.

Top module: `vcfg_unit`

## Requirements
- R1: After a synchronous active-low reset, VL is 0, the width code is 0, the grouping code is 0, no response is valid and `cfg_ready` is low. `cfg_ready` rises on the first clock edge after reset is released.
- R2: A request is accepted when `cfg_valid` and `cfg_ready` are both high at a clock edge. If it is legal and does not ask to keep the length, VL becomes min(`cfg_avl`, VLMAX) at that edge, and the type takes the requested codes.
- R3: VLMAX = 2^VLEN_LOG2 × LMUL / SEW, with VLEN_LOG2 = 8 (256 bits) by default. Width codes 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. Grouping codes 0, 1, 2 and 3 select 1, 2, 4 and 8 registers.
- R4: A width code of 4 to 7 makes the request illegal. VL, the width code and the grouping code all keep their values.
- R5: With `cfg_keep_vl` high, a legal request updates only the type and VL is kept. If the kept VL exceeds the VLMAX of the new type, the request is illegal and nothing changes.
- R6: One cycle after each accepted request, `rsp_valid` is high for exactly one cycle. With it, `rsp_vl` equals the VL now in force and `rsp_illegal` tells whether the request was rejected.
- R7: Without an accepted request, VL and the type hold their values. The old values stay visible on the outputs until the edge that applies an update.
- R8: `spec_bad[i]` is high exactly when specifier i (bits 5i+4..5i of `spec_idx`) is not a multiple of the current group size 2^grouping code. It is combinational on the stored type.
- R9: Repeated requests over a remaining count grant VLMAX on each pass until the remainder is smaller, then grant exactly that remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration request present |
| cfg_ready | output | 1 | Unit can accept a request |
| cfg_avl | input | AVL_W | Requested application length |
| cfg_keep_vl | input | 1 | Keep current VL, change type only |
| cfg_sew | input | 3 | Requested element-width code |
| cfg_lmul | input | 2 | Requested grouping code |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_vl | output | VLEN_LOG2+1 | Granted length |
| rsp_illegal | output | 1 | Request rejected |
| vl | output | VLEN_LOG2+1 | Current vector length |
| vtype_sew | output | 3 | Current element-width code |
| vtype_lmul | output | 2 | Current grouping code |
| spec_idx | input | 5*NSPEC | Packed register specifiers to check |
| spec_bad | output | NSPEC | Per-specifier misalignment flag |

## Verification
On every cycle, the assertions check several invariants. VL never exceeds the maximum of the stored type, and the stored type is always a legal one. Each response follows exactly one accepted request and reports the VL in force. A rejected or keep-length request leaves the length as it was, and register zero and ungrouped operation never report misalignment. Other behaviour shows only through the bench's scenarios against its reference model. These include the exact clamp value for all sixteen width and grouping pairs, and the stripmine sequence ending on the remainder. They also include the rejection of a kept length that no longer fits, and the full sweep of specifiers under every grouping factor.

// File: rtl/vcfg_pkg.sv
// Shared widths and the stored vector type record.
// Assumes 32 vector registers and fixed code widths for the type fields.
package vcfg_pkg;
    localparam int SEW_CODE_W  = 3;
    localparam int LMUL_CODE_W = 2;
    localparam int REG_IDX_W   = 5;
    localparam int MAX_SEW_CODE = 3;
    localparam int MIN_SEW_LOG2 = 3;

    typedef struct packed {
        logic [SEW_CODE_W-1:0]  sew;
        logic [LMUL_CODE_W-1:0] lmul;
    } vtype_t;

    localparam vtype_t VTYPE_RESET = '{sew: '0, lmul: '0};
endpackage

// File: rtl/vcfg_decode.sv
// Turns a width/grouping code pair into a legality flag and the maximum
// vector length. Assumes VLEN_LOG2 >= MIN_SEW_LOG2 + MAX_SEW_CODE so the
// shift never goes negative, and VL_W = VLEN_LOG2 + 1.
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int VLEN_LOG2 = 8,
    parameter int VL_W      = VLEN_LOG2 + 1
) (
    input  vtype_t          code,
    output logic            legal,
    output logic [VL_W-1:0] vlmax
);
    localparam int SHAMT_W = $clog2(VLEN_LOG2 + 8) + 1;

    logic [SHAMT_W-1:0] shamt;

    // Legality of the width code and the power-of-two maximum length.
    always_comb begin
        legal = (int'(code.sew) <= MAX_SEW_CODE);
        shamt = SHAMT_W'(VLEN_LOG2) + SHAMT_W'(code.lmul)
              - SHAMT_W'(MIN_SEW_LOG2) - SHAMT_W'(code.sew);
        vlmax = legal ? ({{(VL_W-1){1'b0}}, 1'b1} << shamt) : '0;
    end
endmodule

// File: rtl/vcfg_grant.sv
// Picks the granted length for a request and decides whether it may be
// applied. Assumes AVL_W >= VL_W.
module vcfg_grant #(
    parameter int AVL_W = 16,
    parameter int VL_W  = 9
) (
    input  logic [AVL_W-1:0] avl,
    input  logic             keep_vl,
    input  logic             type_legal,
    input  logic [VL_W-1:0]  vlmax,
    input  logic [VL_W-1:0]  cur_vl,
    output logic [VL_W-1:0]  grant_vl,
    output logic             accept_ok
);
    logic [AVL_W-1:0] vlmax_ext;

    // Clamp the request, or keep the current length if it still fits.
    always_comb begin
        vlmax_ext = AVL_W'(vlmax);
        if (keep_vl) begin
            grant_vl  = cur_vl;
            accept_ok = type_legal && (cur_vl <= vlmax);
        end else begin
            grant_vl  = (avl < vlmax_ext) ? avl[VL_W-1:0] : vlmax;
            accept_ok = type_legal;
        end
    end
endmodule

// File: rtl/vcfg_spec_check.sv
// Flags each vector register specifier that is not a multiple of the
// current group size. Purely combinational on the data path; clock and
// reset only serve the assertions.
module vcfg_spec_check
    import vcfg_pkg::*;
#(
    parameter int NSPEC = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LMUL_CODE_W-1:0]     lmul_code,
    input  logic [NSPEC*REG_IDX_W-1:0] spec_idx,
    output logic [NSPEC-1:0]           spec_bad
);
    logic [REG_IDX_W-1:0] low_mask;

    // Mask of the specifier bits that must be zero for alignment.
    always_comb low_mask = REG_IDX_W'((1 << lmul_code) - 1);

    for (genvar i = 0; i < NSPEC; i++) begin : g_spec
        logic [REG_IDX_W-1:0] idx;
        // Extract one specifier and test its low bits.
        always_comb begin
            idx         = spec_idx[i*REG_IDX_W +: REG_IDX_W];
            spec_bad[i] = |(idx & low_mask);
        end

        a_r8_reg_zero_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            (idx == '0) |-> !spec_bad[i]);
        a_r8_no_group_never_bad: assert property (@(posedge clk) disable iff (!rst_n)
            (lmul_code == '0) |-> !spec_bad[i]);
    end
endmodule

// File: rtl/vcfg_unit.sv
// Vector length and type configuration unit. Holds VL and the type,
// applies accepted set-length requests in one cycle, answers with a
// one-cycle response, and checks register specifiers against the
// current grouping. Synchronous active-low reset.
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int VLEN_LOG2 = 8,
    parameter int AVL_W     = 16,
    parameter int NSPEC     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_valid,
    output logic                       cfg_ready,
    input  logic [AVL_W-1:0]           cfg_avl,
    input  logic                       cfg_keep_vl,
    input  logic [2:0]                 cfg_sew,
    input  logic [1:0]                 cfg_lmul,
    output logic                       rsp_valid,
    output logic [VLEN_LOG2:0]         rsp_vl,
    output logic                       rsp_illegal,
    output logic [VLEN_LOG2:0]         vl,
    output logic [2:0]                 vtype_sew,
    output logic [1:0]                 vtype_lmul,
    input  logic [NSPEC*5-1:0]         spec_idx,
    output logic [NSPEC-1:0]           spec_bad
);
    localparam int VL_W = VLEN_LOG2 + 1;

    vtype_t          vtype_q, req_type;
    logic [VL_W-1:0] vl_q, req_vlmax, cur_vlmax, grant_vl;
    logic            req_legal, cur_legal, accept_ok, accept;
    logic            ready_q, rsp_valid_q, rsp_ill_q;
    logic [VL_W-1:0] rsp_vl_q;

    // Pack the request type fields.
    always_comb req_type = '{sew: cfg_sew, lmul: cfg_lmul};

    vcfg_decode #(.VLEN_LOG2(VLEN_LOG2), .VL_W(VL_W)) u_req_dec (
        .code(req_type), .legal(req_legal), .vlmax(req_vlmax));

    vcfg_decode #(.VLEN_LOG2(VLEN_LOG2), .VL_W(VL_W)) u_cur_dec (
        .code(vtype_q), .legal(cur_legal), .vlmax(cur_vlmax));

    vcfg_grant #(.AVL_W(AVL_W), .VL_W(VL_W)) u_grant (
        .avl(cfg_avl), .keep_vl(cfg_keep_vl), .type_legal(req_legal),
        .vlmax(req_vlmax), .cur_vl(vl_q), .grant_vl(grant_vl),
        .accept_ok(accept_ok));

    vcfg_spec_check #(.NSPEC(NSPEC)) u_spec (
        .clk(clk), .rst_n(rst_n), .lmul_code(vtype_q.lmul),
        .spec_idx(spec_idx), .spec_bad(spec_bad));

    // Handshake: a request is taken when both sides agree.
    always_comb accept = cfg_valid && ready_q;

    // Architectural state: VL and type, updated only by a legal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q    <= '0;
            vtype_q <= VTYPE_RESET;
        end else if (accept && accept_ok) begin
            vl_q    <= grant_vl;
            vtype_q <= req_type;
        end
    end

    // Response register and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_ill_q   <= 1'b0;
            rsp_vl_q    <= '0;
        end else begin
            ready_q     <= 1'b1;
            rsp_valid_q <= accept;
            if (accept) begin
                rsp_ill_q <= !accept_ok;
                rsp_vl_q  <= accept_ok ? grant_vl : vl_q;
            end
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        cfg_ready   = ready_q;
        rsp_valid   = rsp_valid_q;
        rsp_vl      = rsp_vl_q;
        rsp_illegal = rsp_ill_q;
        vl          = vl_q;
        vtype_sew   = vtype_q.sew;
        vtype_lmul  = vtype_q.lmul;
    end

    a_r2_vl_within_max: assert property (@(posedge clk) disable iff (!rst_n)
        vl_q <= cur_vlmax);
    a_r4_stored_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cur_legal);
    a_r4_reject_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_q && rsp_ill_q) |->
            (vl_q == $past(vl_q) && vtype_q == $past(vtype_q)));
    a_r5_keep_holds_vl: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_q && $past(cfg_keep_vl)) |-> (vl_q == $past(vl_q)));
    a_r6_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_q |-> $past(cfg_valid && ready_q));
    a_r6_rsp_reports_vl: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_q |-> (rsp_vl_q == vl_q));
endmodule

// File: tb/vcfg_unit_test.sv
module vcfg_unit_test;
    localparam int VLEN_LOG2 = 8;
    localparam int AVL_W = 16;
    localparam int NSPEC = 3;
    localparam int VL_W = VLEN_LOG2 + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 1'b0, cfg_keep_vl = 1'b0;
    logic [AVL_W-1:0] cfg_avl = '0;
    logic [2:0] cfg_sew = '0;
    logic [1:0] cfg_lmul = '0;
    logic [NSPEC*5-1:0] spec_idx = '0;
    logic cfg_ready, rsp_valid, rsp_illegal;
    logic [VL_W-1:0] rsp_vl, vl;
    logic [2:0] vtype_sew;
    logic [1:0] vtype_lmul;
    logic [NSPEC-1:0] spec_bad;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;

    // reference state
    int m_vl = 0, m_sew = 0, m_lmul = 0, m_rvl = 0;
    bit m_ready = 0, m_rv = 0, m_rill = 0;

    always #2 clk = ~clk;

    vcfg_unit #(.VLEN_LOG2(VLEN_LOG2), .AVL_W(AVL_W), .NSPEC(NSPEC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
        .cfg_avl(cfg_avl), .cfg_keep_vl(cfg_keep_vl), .cfg_sew(cfg_sew),
        .cfg_lmul(cfg_lmul), .rsp_valid(rsp_valid), .rsp_vl(rsp_vl),
        .rsp_illegal(rsp_illegal), .vl(vl), .vtype_sew(vtype_sew),
        .vtype_lmul(vtype_lmul), .spec_idx(spec_idx), .spec_bad(spec_bad));

    function automatic int ref_vlmax(int s, int l);
        return ((1 << VLEN_LOG2) * (1 << l)) / (8 << s);
    endfunction

    // reference model, advanced at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_vl = 0; m_sew = 0; m_lmul = 0; m_ready = 0; m_rv = 0; m_rill = 0; m_rvl = 0;
        end else begin
            m_rv = 0;
            if (cfg_valid && m_ready) begin
                int s, l, mx, g;
                bit ok;
                s = int'(cfg_sew); l = int'(cfg_lmul);
                ok = (s <= 3);
                mx = ok ? ref_vlmax(s, l) : 0;
                if (cfg_keep_vl) begin g = m_vl; ok = ok && (m_vl <= mx); end
                else g = (int'(cfg_avl) < mx) ? int'(cfg_avl) : mx;
                m_rv = 1; m_rill = !ok;
                if (ok) begin m_vl = g; m_sew = s; m_lmul = l; end
                m_rvl = m_vl;
            end
            m_ready = 1;
        end
    end

    task automatic check(bit good, string req, string what, int act, int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check(int'(vl) == m_vl, "R2", "vl", int'(vl), m_vl);
            check(int'(vtype_sew) == m_sew, "R4", "sew", int'(vtype_sew), m_sew);
            check(int'(vtype_lmul) == m_lmul, "R7", "lmul", int'(vtype_lmul), m_lmul);
            check(cfg_ready == m_ready, "R1", "ready", int'(cfg_ready), int'(m_ready));
            check(rsp_valid == m_rv, "R6", "rsp_valid", int'(rsp_valid), int'(m_rv));
            if (m_rv) begin
                check(int'(rsp_vl) == m_rvl, "R6", "rsp_vl", int'(rsp_vl), m_rvl);
                check(rsp_illegal == m_rill, "R5", "rsp_illegal", int'(rsp_illegal), int'(m_rill));
            end
            for (int i = 0; i < NSPEC; i++) begin
                int idx;
                bit exp_bad;
                idx = int'(spec_idx[i*5 +: 5]);
                exp_bad = (idx % (1 << m_lmul)) != 0;
                check(spec_bad[i] == exp_bad, "R8", "spec_bad", int'(spec_bad[i]), int'(exp_bad));
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic req(int avl, bit keep, int s, int l);
        @(posedge clk); #1;
        cfg_valid = 1; cfg_avl = AVL_W'(avl); cfg_keep_vl = keep;
        cfg_sew = 3'(s); cfg_lmul = 2'(l);
        @(posedge clk); #1;
        cfg_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    initial begin
        // R1 reset state observed by the per-cycle compare
        idle(3);
        @(posedge clk); #1; rst_n = 1;
        idle(2);
        // R2/R3: every width and grouping, large and small requests
        for (int s = 0; s < 4; s++)
            for (int l = 0; l < 4; l++) begin
                req(1000, 0, s, l);
                req(3, 0, s, l);
                req(ref_vlmax(s, l), 0, s, l);
                req(ref_vlmax(s, l) + 1, 0, s, l);
            end
        req(0, 0, 2, 0);
        // R4: illegal width codes leave state alone
        req(40, 0, 1, 1);
        for (int s = 4; s < 8; s++) req(5, 0, s, 2);
        // R5: keep length, fits then does not fit
        req(20, 0, 0, 0);
        req(0, 1, 2, 2);
        req(0, 1, 3, 0);
        req(0, 1, 1, 3);
        // R7: no request, held state; valid while not ready during reset
        idle(4);
        // R9: stripmine 37 elements at 32-bit width, no grouping
        begin
            int rem;
            rem = 37;
            while (rem > 0) begin
                req(rem, 0, 2, 0);
                rem -= (rem < 8) ? rem : 8;
            end
        end
        // R8: sweep specifiers under each grouping
        for (int l = 0; l < 4; l++) begin
            req(8, 0, 0, l);
            for (int r = 0; r < 32; r += 3) begin
                @(posedge clk); #1;
                spec_idx = {5'(r), 5'((r + 1) % 32), 5'((r + 2) % 32)};
            end
        end
        // back-to-back requests
        @(posedge clk); #1;
        cfg_valid = 1; cfg_keep_vl = 0; cfg_avl = 100; cfg_sew = 3; cfg_lmul = 3;
        @(posedge clk); #1; cfg_avl = 2; cfg_sew = 0; cfg_lmul = 1;
        @(posedge clk); #1; cfg_valid = 0;
        idle(3);
        // reset in mid-operation
        rst_n = 0; cfg_valid = 1; cfg_avl = 9;
        idle(2);
        cfg_valid = 0; rst_n = 1;
        idle(3);
        finish_run();
    end
endmodule